// File: doc/BRIEF.md
# Two-Level Indirect Branch Target Predictor

This block supplies predicted targets for indirect jumps and indirect calls. Two structures serve each lookup. The first is a small direct-mapped branch target buffer. Each of its entries holds one static target and a sticky flag that records that the branch has gone somewhere else at least once. The second is a larger tagged target table. It is indexed by the branch address folded with a global history of recent taken-branch targets. A branch that has only ever gone to one place gets its prediction one cycle after lookup, straight from the buffer. A branch that has been seen with more than one target still gets that quick guess first. Three cycles after lookup, a second prediction may then replace the quick guess with the target-table entry chosen by history.

The fetch side presents a PC, a valid and a branch-kind code. The back end presents resolved branches: the PC, the kind, the actual target, whether the branch was taken, the history value that was current at lookup time, and whether the target was mispredicted. The current history value is driven out on `cur_hist` so that the pipeline can carry it to resolve. Returns get no prediction here, and neither do branches of any other kind.

Top module: `indirect_target_predictor`

## Requirements
- R1: Only kind codes 1 (indirect jump) and 2 (indirect call) are eligible. A lookup with kind 0 (other) or kind 3 (return) raises neither `fast_valid` nor `ovr_valid`. A resolve of kind 0 or 3 changes neither the buffer nor the target table.
- R2: A lookup whose buffer entry is invalid, or whose entry holds a different tag, gives `fast_valid` = 0. The buffer is direct-mapped: it is indexed by PC bits [7:2] and tagged by PC bits [31:8]. On an eligible resolve that misses, the entry is filled with the actual target as its static target, and its sticky flag is cleared.
- R3: An eligible lookup that hits in the buffer raises `fast_valid` in the following cycle, with `fast_target` equal to the static target.
- R4: An eligible resolve that hits, and whose actual target differs from the static target, sets the entry's sticky flag. The static target is kept. Later resolves to the static target do not clear the flag. Only a refill by a different tag clears it.
- R5: `ovr_valid` is raised exactly 3 cycles after an eligible lookup that hit an entry with the sticky flag set. It stays 0 for all other lookups.
- R6: The target table is read at index PC[11:2] XOR history[9:0], using the history value at lookup. Each entry stores PC[17:12] as its tag. If the entry is valid and its tag matches, `ovr_target` is the table target. Otherwise `ovr_target` is the static target.
- R7: `ovr_redirect` is 1 exactly when `ovr_valid` is 1 and `ovr_target` differs from the `fast_target` given two cycles earlier for the same lookup.
- R8: Each resolve with `rs_taken` = 1 shifts the history left by 2 bits and inserts `rs_target[3:2]` at the low end. Without such a resolve, the history holds its value. The history appears on `cur_hist` one cycle after the update.
- R9: An eligible resolve with `rs_mispred` = 1 writes the actual target and tag PC[17:12] into the table entry at index PC[11:2] XOR `rs_hist`. A read at the same clock edge returns the old contents.
- R10: A synchronous reset invalidates every buffer and table entry, clears the history, and drops `fast_valid`, `ovr_valid` and `ovr_redirect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Fetch PC of the branch |
| lk_kind | input | 2 | Branch kind: 0 other, 1 indirect jump, 2 indirect call, 3 return |
| rs_valid | input | 1 | Resolved branch this cycle |
| rs_pc | input | 32 | PC of the resolved branch |
| rs_kind | input | 2 | Kind of the resolved branch, same code as lk_kind |
| rs_target | input | 32 | Actual target |
| rs_taken | input | 1 | Branch was taken; drives the history update |
| rs_hist | input | 10 | History value captured at lookup |
| rs_mispred | input | 1 | Target was mispredicted |
| cur_hist | output | 10 | Current global history |
| fast_valid | output | 1 | Quick prediction valid |
| fast_target | output | 32 | Quick prediction target |
| ovr_valid | output | 1 | Second-level prediction valid |
| ovr_target | output | 32 | Second-level prediction target |
| ovr_redirect | output | 1 | Second-level prediction differs from the quick one |

## Verification
The bench targets five corner cases:
- **Sticky flag.** A resolve back to the static target must not clear the flag. A design that cleared it would stop raising `ovr_valid` for a branch known to vary.
- **Refill.** A refill by an aliasing branch must clear the flag. A design that kept it would issue overrides for a branch that has had only one target.
- **Tag mismatch.** A target-table entry left by another branch at the same index must be rejected. A design that skipped the tag compare would redirect to a foreign target.
- **Same-edge read and write.** When a table write and a read fall on the same edge, the read must return the old contents.
- **Returns and other kinds.** Returns and other kinds must leave both structures untouched. A design that let them in would corrupt predictions for the jumps that share an index.

// File: rtl/itp_pkg.sv
package itp_pkg;

   typedef enum logic [1:0] {
      BK_OTHER = 2'd0,
      BK_IJMP  = 2'd1,
      BK_ICALL = 2'd2,
      BK_RET   = 2'd3
   } br_kind_e;

   function automatic logic is_elig(input logic [1:0] k);
      return (k == BK_IJMP) || (k == BK_ICALL);
   endfunction

endpackage

// File: rtl/itp_btb.sv
module itp_btb #(
   parameter int PC_W  = 32,
   parameter int IDX_W = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PC_W-1:0] rd_pc,
   output logic            rd_hit,
   output logic            rd_poly,
   output logic [PC_W-1:0] rd_tgt,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic [PC_W-1:0] wr_tgt
);
   localparam int TAG_W = PC_W - IDX_W - 2;
   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] vld_q;
   logic [DEPTH-1:0] poly_q;
   logic [TAG_W-1:0] tag_m [DEPTH];
   logic [PC_W-1:0]  tgt_m [DEPTH];

   logic [IDX_W-1:0] ridx, widx;
   logic [TAG_W-1:0] rtag, wtag;
   logic             whit;
   logic             unused_lo;

   assign ridx      = rd_pc[IDX_W+1:2];
   assign rtag      = rd_pc[PC_W-1:IDX_W+2];
   assign widx      = wr_pc[IDX_W+1:2];
   assign wtag      = wr_pc[PC_W-1:IDX_W+2];
   assign unused_lo = ^{rd_pc[1:0], wr_pc[1:0]};

   assign rd_hit  = vld_q[ridx] && (tag_m[ridx] == rtag);
   assign rd_poly = poly_q[ridx];
   assign rd_tgt  = tgt_m[ridx];
   assign whit    = vld_q[widx] && (tag_m[widx] == wtag);

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q  <= '0;
         poly_q <= '0;
      end else if (wr_en) begin
         if (!whit) begin
            vld_q[widx]  <= 1'b1;
            poly_q[widx] <= 1'b0;
         end else if (tgt_m[widx] != wr_tgt) begin
            poly_q[widx] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !whit) begin
         tag_m[widx] <= wtag;
         tgt_m[widx] <= wr_tgt;
      end
   end

endmodule

// File: rtl/itp_tarray.sv
module itp_tarray #(
   parameter int PC_W  = 32,
   parameter int IDX_W = 10,
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_vld,
   output logic [TAG_W-1:0] rd_tag,
   output logic [PC_W-1:0]  rd_tgt,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PC_W-1:0]  wr_tgt
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] vld_q;
   logic [TAG_W-1:0] tag_m [DEPTH];
   logic [PC_W-1:0]  tgt_m [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q  <= '0;
         rd_vld <= 1'b0;
      end else begin
         rd_vld <= vld_q[rd_idx];
         if (wr_en) vld_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      rd_tag <= tag_m[rd_idx];
      rd_tgt <= tgt_m[rd_idx];
      if (wr_en) begin
         tag_m[wr_idx] <= wr_tag;
         tgt_m[wr_idx] <= wr_tgt;
      end
   end

endmodule

// File: rtl/itp_ghist.sv
module itp_ghist #(
   parameter int HIST_W  = 10,
   parameter int SHIFT_W = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               upd,
   input  logic [SHIFT_W-1:0] fresh,
   output logic [HIST_W-1:0]  hist
);
   logic [HIST_W-1:0] nxt;

   generate
      if (SHIFT_W < HIST_W) begin : g_shift
         assign nxt = {hist[HIST_W-SHIFT_W-1:0], fresh};
      end else begin : g_whole
         assign nxt = fresh;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)      hist <= '0;
      else if (upd) hist <= nxt;
   end

endmodule

// File: rtl/indirect_target_predictor.sv
module indirect_target_predictor #(
   parameter int PC_W      = 32,
   parameter int BTB_IDX_W = 6,
   parameter int ITA_IDX_W = 10,
   parameter int ITA_TAG_W = 6,
   parameter int HIST_W    = 10,
   parameter int SHIFT_W   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              lk_valid,
   input  logic [PC_W-1:0]   lk_pc,
   input  logic [1:0]        lk_kind,
   input  logic              rs_valid,
   input  logic [PC_W-1:0]   rs_pc,
   input  logic [1:0]        rs_kind,
   input  logic [PC_W-1:0]   rs_target,
   input  logic              rs_taken,
   input  logic [HIST_W-1:0] rs_hist,
   input  logic              rs_mispred,
   output logic [HIST_W-1:0] cur_hist,
   output logic              fast_valid,
   output logic [PC_W-1:0]   fast_target,
   output logic              ovr_valid,
   output logic [PC_W-1:0]   ovr_target,
   output logic              ovr_redirect
);
   import itp_pkg::*;

   localparam int TAG_LO = ITA_IDX_W + 2;
   localparam int TAG_HI = ITA_IDX_W + ITA_TAG_W + 1;

   generate
      if (HIST_W < ITA_IDX_W) begin : g_bad_hist
         $fatal(1, "history narrower than table index");
      end
      if (TAG_HI >= PC_W) begin : g_bad_tag
         $fatal(1, "table tag exceeds PC width");
      end
      if (SHIFT_W < 1 || SHIFT_W > HIST_W || SHIFT_W + 2 > PC_W) begin : g_bad_shift
         $fatal(1, "bad history shift width");
      end
      if (BTB_IDX_W + 2 >= PC_W) begin : g_bad_btb
         $fatal(1, "buffer index exceeds PC width");
      end
   endgenerate

   // buffer
   logic            b_hit, b_poly;
   logic [PC_W-1:0] b_tgt;

   itp_btb #(.PC_W(PC_W), .IDX_W(BTB_IDX_W)) u_btb (
      .clk(clk), .rst(rst),
      .rd_pc(lk_pc), .rd_hit(b_hit), .rd_poly(b_poly), .rd_tgt(b_tgt),
      .wr_en(rs_valid && is_elig(rs_kind)), .wr_pc(rs_pc), .wr_tgt(rs_target)
   );

   // history
   itp_ghist #(.HIST_W(HIST_W), .SHIFT_W(SHIFT_W)) u_hist (
      .clk(clk), .rst(rst),
      .upd(rs_valid && rs_taken), .fresh(rs_target[SHIFT_W+1:2]),
      .hist(cur_hist)
   );

   // stage 1: quick prediction, table address captured
   logic                 s1_poly;
   logic [ITA_IDX_W-1:0] s1_idx;
   logic [ITA_TAG_W-1:0] s1_tag;

   always_ff @(posedge clk) begin
      if (rst) begin
         fast_valid  <= 1'b0;
         fast_target <= '0;
         s1_poly     <= 1'b0;
         s1_idx      <= '0;
         s1_tag      <= '0;
      end else begin
         fast_valid  <= lk_valid && is_elig(lk_kind) && b_hit;
         fast_target <= b_tgt;
         s1_poly     <= b_poly;
         s1_idx      <= lk_pc[ITA_IDX_W+1:2] ^ cur_hist[ITA_IDX_W-1:0];
         s1_tag      <= lk_pc[TAG_HI:TAG_LO];
      end
   end

   // target table
   logic                 a_vld;
   logic [ITA_TAG_W-1:0] a_tag;
   logic [PC_W-1:0]      a_tgt;

   itp_tarray #(.PC_W(PC_W), .IDX_W(ITA_IDX_W), .TAG_W(ITA_TAG_W)) u_arr (
      .clk(clk), .rst(rst),
      .rd_idx(s1_idx), .rd_vld(a_vld), .rd_tag(a_tag), .rd_tgt(a_tgt),
      .wr_en(rs_valid && is_elig(rs_kind) && rs_mispred),
      .wr_idx(rs_pc[ITA_IDX_W+1:2] ^ rs_hist[ITA_IDX_W-1:0]),
      .wr_tag(rs_pc[TAG_HI:TAG_LO]),
      .wr_tgt(rs_target)
   );

   // stage 2: wait for table data
   logic                 s2_v;
   logic [ITA_TAG_W-1:0] s2_tag;
   logic [PC_W-1:0]      s2_stat;

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_v    <= 1'b0;
         s2_tag  <= '0;
         s2_stat <= '0;
      end else begin
         s2_v    <= fast_valid && s1_poly;
         s2_tag  <= s1_tag;
         s2_stat <= fast_target;
      end
   end

   // stage 3: override
   logic use_arr;
   assign use_arr = a_vld && (a_tag == s2_tag);

   always_ff @(posedge clk) begin
      if (rst) begin
         ovr_valid    <= 1'b0;
         ovr_target   <= '0;
         ovr_redirect <= 1'b0;
      end else begin
         ovr_valid    <= s2_v;
         ovr_target   <= use_arr ? a_tgt : s2_stat;
         ovr_redirect <= s2_v && use_arr && (a_tgt != s2_stat);
      end
   end

endmodule

// File: rtl/itp_chk.sv
module itp_chk #(
   parameter int PC_W    = 32,
   parameter int HIST_W  = 10,
   parameter int SHIFT_W = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              lk_valid,
   input logic [1:0]        lk_kind,
   input logic              rs_valid,
   input logic [PC_W-1:0]   rs_target,
   input logic              rs_taken,
   input logic [HIST_W-1:0] cur_hist,
   input logic              fast_valid,
   input logic [PC_W-1:0]   fast_target,
   input logic              ovr_valid,
   input logic [PC_W-1:0]   ovr_target,
   input logic              ovr_redirect
);
   import itp_pkg::*;

   AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      fast_valid |-> ($past(lk_valid) && is_elig($past(lk_kind)))); // R3

   AST_OVR_LATENCY: assert property (@(posedge clk) disable iff (rst)
      ovr_valid |-> $past(lk_valid, 3)); // R5

   AST_RET_NO_OVR: assert property (@(posedge clk) disable iff (rst)
      ovr_valid |-> ($past(lk_kind, 3) != BK_RET)); // R1

   AST_REDIR_DIFF: assert property (@(posedge clk) disable iff (rst)
      ovr_valid |-> (ovr_redirect == (ovr_target != $past(fast_target, 2)))); // R7

   AST_REDIR_QUAL: assert property (@(posedge clk) disable iff (rst)
      ovr_redirect |-> ovr_valid); // R7

   AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(rs_valid && rs_taken) |=> $stable(cur_hist)); // R8

   AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
      (rs_valid && rs_taken) |=> (cur_hist[SHIFT_W-1:0] == $past(rs_target[SHIFT_W+1:2]))); // R8

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!fast_valid && !ovr_valid && !ovr_redirect && cur_hist == '0)); // R10

endmodule

bind indirect_target_predictor itp_chk #(.PC_W(PC_W), .HIST_W(HIST_W), .SHIFT_W(SHIFT_W)) u_chk (
   .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_kind(lk_kind),
   .rs_valid(rs_valid), .rs_target(rs_target), .rs_taken(rs_taken),
   .cur_hist(cur_hist), .fast_valid(fast_valid), .fast_target(fast_target),
   .ovr_valid(ovr_valid), .ovr_target(ovr_target), .ovr_redirect(ovr_redirect)
);

// File: tb/tb_indirect_target_predictor.sv
`timescale 1ns/1ps
module tb_indirect_target_predictor;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic [1:0]  lk_kind = '0;
   logic        rs_valid = 1'b0;
   logic [31:0] rs_pc = '0;
   logic [1:0]  rs_kind = '0;
   logic [31:0] rs_target = '0;
   logic        rs_taken = 1'b0;
   logic [9:0]  rs_hist = '0;
   logic        rs_mispred = 1'b0;
   logic [9:0]  cur_hist;
   logic        fast_valid, ovr_valid, ovr_redirect;
   logic [31:0] fast_target, ovr_target;

   indirect_target_predictor dut (
      .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_kind(lk_kind),
      .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_kind(rs_kind), .rs_target(rs_target),
      .rs_taken(rs_taken), .rs_hist(rs_hist), .rs_mispred(rs_mispred),
      .cur_hist(cur_hist), .fast_valid(fast_valid), .fast_target(fast_target),
      .ovr_valid(ovr_valid), .ovr_target(ovr_target), .ovr_redirect(ovr_redirect)
   );

   always #10 clk = ~clk;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // reference model state
   bit        m_bv   [64];
   bit [23:0] m_btag [64];
   bit [31:0] m_btgt [64];
   bit        m_bpoly[64];
   bit        m_av   [1024];
   bit [5:0]  m_atag [1024];
   bit [31:0] m_atgt [1024];
   bit [9:0]  m_hist;

   bit        p1_v, p1_poly;
   bit [31:0] p1_stat;
   int        p1_idx;
   bit [5:0]  p1_tag;
   bit        p2_v, p2_av;
   bit [31:0] p2_stat, p2_atgt;
   bit [5:0]  p2_tag, p2_atag;
   bit        e_fv, e_ov, e_rd;
   bit [31:0] e_ft, e_ot;

   function automatic bit elig(input logic [1:0] k);
      return (k == 2'd1) || (k == 2'd2);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 64; i++) begin m_bv[i] = 0; m_bpoly[i] = 0; end
         for (int i = 0; i < 1024; i++) m_av[i] = 0;
         m_hist = '0;
         p1_v = 0; p2_v = 0; e_fv = 0; e_ov = 0; e_rd = 0;
      end else begin
         int bi;
         bit hit;
         e_ov = p2_v;
         e_ot = (p2_av && p2_atag == p2_tag) ? p2_atgt : p2_stat;
         e_rd = p2_v && (e_ot != p2_stat);
         p2_v    = p1_v && p1_poly;
         p2_stat = p1_stat;
         p2_tag  = p1_tag;
         p2_av   = m_av[p1_idx];
         p2_atag = m_atag[p1_idx];
         p2_atgt = m_atgt[p1_idx];
         bi      = int'(lk_pc[7:2]);
         hit     = m_bv[bi] && (m_btag[bi] == lk_pc[31:8]);
         p1_v    = lk_valid && elig(lk_kind) && hit;
         p1_poly = m_bpoly[bi];
         p1_stat = m_btgt[bi];
         p1_idx  = int'(lk_pc[11:2] ^ m_hist);
         p1_tag  = lk_pc[17:12];
         e_fv    = p1_v;
         e_ft    = p1_stat;
         if (rs_valid && elig(rs_kind)) begin
            int wi;
            wi = int'(rs_pc[7:2]);
            if (!(m_bv[wi] && m_btag[wi] == rs_pc[31:8])) begin
               m_bv[wi] = 1; m_btag[wi] = rs_pc[31:8]; m_btgt[wi] = rs_target; m_bpoly[wi] = 0;
            end else if (m_btgt[wi] != rs_target) begin
               m_bpoly[wi] = 1;
            end
            if (rs_mispred) begin
               int ai;
               ai = int'(rs_pc[11:2] ^ rs_hist);
               m_av[ai] = 1; m_atag[ai] = rs_pc[17:12]; m_atgt[ai] = rs_target;
            end
         end
         if (rs_valid && rs_taken) m_hist = {m_hist[7:0], rs_target[3:2]};
      end
   end

   always @(negedge clk) begin
      if (!rst && !done) begin
         check("R3 fast_valid", {31'd0, fast_valid}, {31'd0, e_fv});
         if (e_fv) check("R3 fast_target", fast_target, e_ft);
         check("R5 ovr_valid", {31'd0, ovr_valid}, {31'd0, e_ov});
         if (e_ov) check("R6 ovr_target", ovr_target, e_ot);
         check("R7 ovr_redirect", {31'd0, ovr_redirect}, {31'd0, e_rd});
         check("R8 cur_hist", {22'd0, cur_hist}, {22'd0, m_hist});
      end
   end

   task automatic cyc(input bit lv, input logic [31:0] lpc, input logic [1:0] lk,
                      input bit rv, input logic [31:0] rpc, input logic [1:0] rk,
                      input logic [31:0] rt, input bit rtk, input logic [9:0] rh, input bit rm);
      lk_valid = lv; lk_pc = lpc; lk_kind = lk;
      rs_valid = rv; rs_pc = rpc; rs_kind = rk; rs_target = rt;
      rs_taken = rtk; rs_hist = rh; rs_mispred = rm;
      @(negedge clk);
   endtask

   task automatic look(input logic [31:0] pc, input logic [1:0] k);
      cyc(1, pc, k, 0, '0, '0, '0, 0, '0, 0);
   endtask

   task automatic res(input logic [31:0] pc, input logic [1:0] k, input logic [31:0] t,
                      input bit tk, input logic [9:0] h, input bit mis);
      cyc(0, '0, '0, 1, pc, k, t, tk, h, mis);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, '0, '0, '0, 0, '0, 0);
   endtask

   function automatic logic [31:0] pool_pc(input int i);
      return 32'h0000_0100 | (32'(i & 3) << 2) | (32'((i >> 2) & 3) << 12);
   endfunction

   initial begin
      logic [31:0] pa, pc2;
      pa  = 32'h0000_1234;
      pc2 = 32'h0000_2234;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check("R10 fast_valid after reset", {31'd0, fast_valid}, 32'd0);
      check("R10 ovr_valid after reset", {31'd0, ovr_valid}, 32'd0);
      check("R10 cur_hist after reset", {22'd0, cur_hist}, 32'd0);

      look(pa, 2'd1);
      check("R2 miss gives no fast", {31'd0, fast_valid}, 32'd0);
      res(pa, 2'd1, 32'h0000_2000, 0, 10'd0, 1);
      look(pa, 2'd1);
      check("R3 fast hit", {31'd0, fast_valid}, 32'd1);
      check("R3 fast static", fast_target, 32'h0000_2000);
      idle(2);
      check("R5 single target no ovr", {31'd0, ovr_valid}, 32'd0);

      res(pa, 2'd2, 32'h0000_3000, 0, 10'd0, 1);
      look(pa, 2'd1);
      check("R4 static kept", fast_target, 32'h0000_2000);
      idle(2);
      check("R5 poly ovr", {31'd0, ovr_valid}, 32'd1);
      check("R9 table target", ovr_target, 32'h0000_3000);
      check("R7 redirect", {31'd0, ovr_redirect}, 32'd1);

      res(pa, 2'd1, 32'h0000_2000, 0, 10'd0, 0);
      look(pa, 2'd1);
      idle(2);
      check("R4 flag sticky", {31'd0, ovr_valid}, 32'd1);

      res(pa, 2'd3, 32'h0000_7000, 0, 10'd0, 1);
      res(pa, 2'd0, 32'h0000_7000, 0, 10'd0, 1);
      look(pa, 2'd3);
      check("R1 return no fast", {31'd0, fast_valid}, 32'd0);
      look(pa, 2'd0);
      check("R1 other no fast", {31'd0, fast_valid}, 32'd0);
      idle(1);
      check("R1 return no ovr", {31'd0, ovr_valid}, 32'd0);
      look(pa, 2'd2);
      idle(2);
      check("R1 ignored resolves left table", ovr_target, 32'h0000_3000);

      res(pc2, 2'd1, 32'h0000_5000, 0, 10'd0, 0);
      look(pc2, 2'd1);
      check("R2 refill static", fast_target, 32'h0000_5000);
      idle(2);
      check("R4 refill clears flag", {31'd0, ovr_valid}, 32'd0);
      res(pc2, 2'd1, 32'h0000_6000, 0, 10'd0, 0);
      look(pc2, 2'd1);
      idle(2);
      check("R6 tag mismatch ovr valid", {31'd0, ovr_valid}, 32'd1);
      check("R6 tag mismatch keeps static", ovr_target, 32'h0000_5000);
      check("R6 tag mismatch no redirect", {31'd0, ovr_redirect}, 32'd0);

      res(32'h0000_0500, 2'd0, 32'h0000_400C, 1, 10'd0, 0);
      check("R8 shift in", {22'd0, cur_hist}, 32'h003);
      res(32'h0000_0500, 2'd0, 32'h0000_4008, 1, 10'd0, 0);
      check("R8 second shift", {22'd0, cur_hist}, 32'h00E);

      for (int n = 0; n < 3000; n++) begin
         int pi, ti;
         logic [9:0] h;
         pi = int'($urandom_range(0, 15));
         ti = int'($urandom_range(0, 7));
         h  = ($urandom_range(0, 3) == 0) ? 10'($urandom) : m_hist;
         cyc($urandom_range(0, 1) == 1, pool_pc(int'($urandom_range(0, 15))),
             2'($urandom_range(0, 3)),
             $urandom_range(0, 2) != 0, pool_pc(pi), 2'($urandom_range(0, 3)),
             32'h0000_4000 + 32'(ti << 2), $urandom_range(0, 1) == 1, h,
             $urandom_range(0, 1) == 1);
      end

      rst = 1'b1;
      idle(2);
      rst = 1'b0;
      look(pool_pc(0), 2'd1);
      check("R10 reset invalidates", {31'd0, fast_valid}, 32'd0);
      idle(3);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule